// File: doc/BRIEF.md
# Variable-Page Translation Lookup Unit

This block is a fully associative address-translation cache of 64 entries. Software-side logic loads entries through a write port and retires them through an invalidate port. Each entry maps one page of effective address space, tagged by an 8-bit translation ID and a one-bit address-space flag, onto a 36-bit physical page. Every entry carries its own page-size code, so 1 KiB pages and 256 MiB pages can sit side by side in the same array.

A lookup presents an effective address, an ID, a space flag, an access kind (read, write or execute) and a privilege level. All entries are compared in parallel in one cycle. The outcome is registered and shows on the result port on the next cycle: a hit flag, the index of the winning entry, the physical address, the user and storage attribute bits, a multiple-match flag and a permission-fault flag. Exception delivery and table walking happen elsewhere.

Top module: `ptlb_top`

## Requirements
- R1: A synchronous active-high reset clears every entry's valid bit and all result outputs; a lookup made after reset misses.
- R2: The result of a lookup presented with `lk_req` high appears on the result port on the next rising edge, with `rs_valid` high for exactly that cycle; `rs_valid` is low after a cycle with no request.
- R3: An entry matches only if its valid bit is set, its stored ID equals `lk_tid`, its space flag equals `lk_ts`, and the effective-address bits above its page offset equal the corresponding bits of its stored page number (`lk_ea[31:10]` against the 22-bit page number).
- R4: Page size is 1 KiB × 4^code; only codes 0, 1, 2, 3, 4, 5, 7 and 9 are accepted, and an entry holding any other code never matches. For code s the low 2·s bits of the stored page number are not compared.
- R5: On a hit `rs_pa` equals {extended real page (4 bits), real page bits above the page offset, effective-address bits below the page offset}.
- R6: When several entries match, the lowest-numbered one is reported and `rs_multi` is raised; with one match `rs_multi` is low.
- R7: Permission bits, bit 5 down to 0: user execute, user write, user read, supervisor execute, supervisor write, supervisor read. Access code 0 is read, 1 write, 2 execute, 3 is treated as read; `lk_super` high selects the supervisor bits. A hit whose selected bit is clear raises `rs_fault`.
- R8: On a hit the entry's 4 user attribute bits and 5 storage bits (write-through bit 4, caching-inhibited bit 3, coherent bit 2, guarded bit 1, little-endian bit 0) appear on `rs_uattr`/`rs_stor`; on a miss index, address, attributes, fault and multi-match outputs are all zero.
- R9: Invalidating an entry clears its valid bit so it no longer matches; if a write and an invalidate name the same entry in one cycle, the entry ends up invalid.
- R10: A write takes effect for lookups presented from the next cycle on; a lookup in the same cycle as a write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_live | input | 1 | Valid bit to store |
| wr_tid | input | 8 | Translation ID to store |
| wr_ts | input | 1 | Address-space flag to store |
| wr_size | input | 4 | Page-size code to store |
| wr_epn | input | 22 | Effective page number |
| wr_rpn | input | 22 | Real page number |
| wr_xrpn | input | 4 | Extended real page number |
| wr_uattr | input | 4 | User attribute bits |
| wr_stor | input | 5 | Storage attribute bits |
| wr_perm | input | 6 | Permission bits |
| inv_en | input | 1 | Invalidate strobe |
| inv_idx | input | 6 | Entry index to invalidate |
| lk_req | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address |
| lk_tid | input | 8 | Request translation ID |
| lk_ts | input | 1 | Request address-space flag |
| lk_acc | input | 2 | Access kind |
| lk_super | input | 1 | Supervisor privilege |
| rs_valid | output | 1 | Result valid |
| rs_hit | output | 1 | Some entry matched |
| rs_multi | output | 1 | More than one entry matched |
| rs_idx | output | 6 | Index of reported entry |
| rs_pa | output | 36 | Physical address |
| rs_uattr | output | 4 | User attribute bits |
| rs_stor | output | 5 | Storage attribute bits |
| rs_fault | output | 1 | Permission fault |

## Verification
Lookups are tried against entries of 4 KiB, 1 KiB, 1 MiB, 16 MiB and 256 MiB pages, so a wrong compare mask or a wrong offset splice in the physical address shows up at a specific size. Requests that differ from a loaded entry in only the ID or only the space flag separate the tag checks from the page compare. A small page nested inside a large one tells priority order and the multi-match flag apart, and an entry holding an unsupported size code is shown to miss before the same entry with a legal code hits. One entry with alternating permission bits is probed with all six mode/access pairs, and same-cycle write/lookup and write/invalidate collisions pin the update ordering.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

    localparam int EA_W    = 32;
    localparam int MIN_OFS = 10;
    localparam int EPN_W   = EA_W - MIN_OFS;
    localparam int RPN_W   = EPN_W;
    localparam int XRPN_W  = 4;
    localparam int PA_W    = XRPN_W + EA_W;
    localparam int TID_W   = 8;
    localparam int SZ_W    = 4;
    localparam int UATTR_W = 4;
    localparam int STOR_W  = 5;
    localparam int PERM_W  = 6;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic               live;
        logic [TID_W-1:0]   tid;
        logic               space;
        logic [SZ_W-1:0]    szsel;
        logic [EPN_W-1:0]   epn;
        logic [RPN_W-1:0]   rpn;
        logic [XRPN_W-1:0]  xrpn;
        logic [UATTR_W-1:0] uattr;
        logic [STOR_W-1:0]  stor;
        logic [PERM_W-1:0]  perm;
    } ent_t;

    // Accepted page-size codes
    function automatic logic size_ok(input logic [SZ_W-1:0] s);
        case (s)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd7, 4'd9: size_ok = 1'b1;
            default:                                        size_ok = 1'b0;
        endcase
    endfunction

    // Page-number bits that take part in the compare for a given size code
    function automatic logic [EPN_W-1:0] cmp_mask(input logic [SZ_W-1:0] s);
        logic [EPN_W-1:0] m;
        m = '1;
        if (size_ok(s)) m = m << (2 * s);
        else            m = '0;
        return m;
    endfunction

    // Position of the permission bit selected by mode and access kind
    function automatic logic [2:0] perm_pos(input logic sup, input acc_e acc);
        logic [2:0] base;
        base = sup ? 3'd0 : 3'd3;
        case (acc)
            ACC_WRITE: perm_pos = base + 3'd1;
            ACC_EXEC:  perm_pos = base + 3'd2;
            default:   perm_pos = base;
        endcase
    endfunction

endpackage

// File: rtl/ptlb_store.sv
module ptlb_store
    import ptlb_pkg::*;
#(
    parameter int NUM_ENT = 64,
    localparam int IDX_W = $clog2(NUM_ENT)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  ent_t                    wr_ent,
    input  logic                    inv_en,
    input  logic [IDX_W-1:0]        inv_idx,
    output ent_t [NUM_ENT-1:0]      ents
);

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[g] <= '0;
            end else begin
                if (wr_en && wr_idx == IDX_W'(g))
                    ents[g] <= wr_ent;
                // invalidate is applied last so it wins a same-index collision
                if (inv_en && inv_idx == IDX_W'(g))
                    ents[g].live <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ptlb_compare.sv
module ptlb_compare
    import ptlb_pkg::*;
#(
    parameter int NUM_ENT = 64
) (
    input  ent_t [NUM_ENT-1:0] ents,
    input  logic [EA_W-1:0]    lk_ea,
    input  logic [TID_W-1:0]   lk_tid,
    input  logic               lk_ts,
    output logic [NUM_ENT-1:0] hits
);

    logic [EPN_W-1:0] req_pn;
    assign req_pn = lk_ea[EA_W-1:MIN_OFS];

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        logic [EPN_W-1:0] diff;
        logic             tag_eq;
        assign diff   = (req_pn ^ ents[g].epn) & cmp_mask(ents[g].szsel);
        assign tag_eq = (ents[g].tid == lk_tid) && (ents[g].space == lk_ts);
        assign hits[g] = ents[g].live && size_ok(ents[g].szsel) && tag_eq && (diff == '0);
    end

endmodule

// File: rtl/ptlb_select.sv
module ptlb_select
    import ptlb_pkg::*;
#(
    parameter int NUM_ENT = 64,
    localparam int IDX_W = $clog2(NUM_ENT)
) (
    input  ent_t [NUM_ENT-1:0]  ents,
    input  logic [NUM_ENT-1:0]  hits,
    input  logic [EA_W-1:0]     lk_ea,
    input  acc_e                lk_acc,
    input  logic                lk_super,
    output logic                o_hit,
    output logic                o_multi,
    output logic [IDX_W-1:0]    o_idx,
    output logic [PA_W-1:0]     o_pa,
    output logic [UATTR_W-1:0]  o_uattr,
    output logic [STOR_W-1:0]   o_stor,
    output logic                o_fault
);

    logic [IDX_W-1:0] sel;
    ent_t             win;
    logic [EA_W-1:0]  ofs_mask;
    logic [EA_W-1:0]  real_base;

    // lowest-numbered match wins
    always_comb begin
        sel = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (hits[i]) sel = IDX_W'(i);
        end
    end

    assign win       = ents[sel];
    assign ofs_mask  = {~cmp_mask(win.szsel), {MIN_OFS{1'b1}}};
    assign real_base = {win.rpn, {MIN_OFS{1'b0}}};

    always_comb begin
        o_hit   = |hits;
        o_multi = (hits & (hits - 1'b1)) != '0;
        o_idx   = '0;
        o_pa    = '0;
        o_uattr = '0;
        o_stor  = '0;
        o_fault = 1'b0;
        if (o_hit) begin
            o_idx   = sel;
            o_pa    = {win.xrpn, (real_base & ~ofs_mask) | (lk_ea & ofs_mask)};
            o_uattr = win.uattr;
            o_stor  = win.stor;
            o_fault = ~win.perm[perm_pos(lk_super, lk_acc)];
        end
    end

endmodule

// File: rtl/ptlb_top.sv
module ptlb_top
    import ptlb_pkg::*;
#(
    parameter int NUM_ENT = 64,
    localparam int IDX_W = $clog2(NUM_ENT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_live,
    input  logic [TID_W-1:0]   wr_tid,
    input  logic               wr_ts,
    input  logic [SZ_W-1:0]    wr_size,
    input  logic [EPN_W-1:0]   wr_epn,
    input  logic [RPN_W-1:0]   wr_rpn,
    input  logic [XRPN_W-1:0]  wr_xrpn,
    input  logic [UATTR_W-1:0] wr_uattr,
    input  logic [STOR_W-1:0]  wr_stor,
    input  logic [PERM_W-1:0]  wr_perm,
    input  logic               inv_en,
    input  logic [IDX_W-1:0]   inv_idx,
    input  logic               lk_req,
    input  logic [EA_W-1:0]    lk_ea,
    input  logic [TID_W-1:0]   lk_tid,
    input  logic               lk_ts,
    input  logic [1:0]         lk_acc,
    input  logic               lk_super,
    output logic               rs_valid,
    output logic               rs_hit,
    output logic               rs_multi,
    output logic [IDX_W-1:0]   rs_idx,
    output logic [PA_W-1:0]    rs_pa,
    output logic [UATTR_W-1:0] rs_uattr,
    output logic [STOR_W-1:0]  rs_stor,
    output logic               rs_fault
);

    ent_t [NUM_ENT-1:0] ents;
    ent_t               wr_ent;
    logic [NUM_ENT-1:0] hits;

    logic               c_hit, c_multi, c_fault;
    logic [IDX_W-1:0]   c_idx;
    logic [PA_W-1:0]    c_pa;
    logic [UATTR_W-1:0] c_uattr;
    logic [STOR_W-1:0]  c_stor;

    always_comb begin
        wr_ent.live  = wr_live;
        wr_ent.tid   = wr_tid;
        wr_ent.space = wr_ts;
        wr_ent.szsel = wr_size;
        wr_ent.epn   = wr_epn;
        wr_ent.rpn   = wr_rpn;
        wr_ent.xrpn  = wr_xrpn;
        wr_ent.uattr = wr_uattr;
        wr_ent.stor  = wr_stor;
        wr_ent.perm  = wr_perm;
    end

    ptlb_store #(.NUM_ENT(NUM_ENT)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_ent  (wr_ent),
        .inv_en  (inv_en),
        .inv_idx (inv_idx),
        .ents    (ents)
    );

    ptlb_compare #(.NUM_ENT(NUM_ENT)) u_cmp (
        .ents   (ents),
        .lk_ea  (lk_ea),
        .lk_tid (lk_tid),
        .lk_ts  (lk_ts),
        .hits   (hits)
    );

    ptlb_select #(.NUM_ENT(NUM_ENT)) u_sel (
        .ents     (ents),
        .hits     (hits),
        .lk_ea    (lk_ea),
        .lk_acc   (acc_e'(lk_acc)),
        .lk_super (lk_super),
        .o_hit    (c_hit),
        .o_multi  (c_multi),
        .o_idx    (c_idx),
        .o_pa     (c_pa),
        .o_uattr  (c_uattr),
        .o_stor   (c_stor),
        .o_fault  (c_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_valid <= 1'b0;
            rs_hit   <= 1'b0;
            rs_multi <= 1'b0;
            rs_idx   <= '0;
            rs_pa    <= '0;
            rs_uattr <= '0;
            rs_stor  <= '0;
            rs_fault <= 1'b0;
        end else begin
            rs_valid <= lk_req;
            rs_hit   <= c_hit;
            rs_multi <= c_multi;
            rs_idx   <= c_idx;
            rs_pa    <= c_pa;
            rs_uattr <= c_uattr;
            rs_stor  <= c_stor;
            rs_fault <= c_fault;
        end
    end

endmodule

// File: rtl/ptlb_checker.sv
module ptlb_checker
    import ptlb_pkg::*;
#(
    parameter int NUM_ENT = 64,
    localparam int IDX_W = $clog2(NUM_ENT)
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_req,
    input logic [EA_W-1:0]    lk_ea,
    input logic               rs_valid,
    input logic               rs_hit,
    input logic               rs_multi,
    input logic [IDX_W-1:0]   rs_idx,
    input logic [PA_W-1:0]    rs_pa,
    input logic [UATTR_W-1:0] rs_uattr,
    input logic [STOR_W-1:0]  rs_stor,
    input logic               rs_fault
);

    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rs_valid && !rs_hit && rs_pa == '0));

    a_r2_result_follows_req: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> rs_valid);

    a_r2_no_req_no_result: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !rs_valid);

    a_r5_min_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (lk_req && !$past(rst)) |=> (!rs_hit || rs_pa[MIN_OFS-1:0] == $past(lk_ea[MIN_OFS-1:0])));

    a_r6_multi_needs_hit: assert property (@(posedge clk) disable iff (rst)
        rs_multi |-> rs_hit);

    a_r7_fault_needs_hit: assert property (@(posedge clk) disable iff (rst)
        rs_fault |-> rs_hit);

    a_r8_miss_is_zero: assert property (@(posedge clk) disable iff (rst)
        !rs_hit |-> (rs_pa == '0 && rs_idx == '0 && rs_uattr == '0 && rs_stor == '0));

endmodule

bind ptlb_top ptlb_checker #(.NUM_ENT(NUM_ENT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lk_req   (lk_req),
    .lk_ea    (lk_ea),
    .rs_valid (rs_valid),
    .rs_hit   (rs_hit),
    .rs_multi (rs_multi),
    .rs_idx   (rs_idx),
    .rs_pa    (rs_pa),
    .rs_uattr (rs_uattr),
    .rs_stor  (rs_stor),
    .rs_fault (rs_fault)
);

// File: tb/test_ptlb_top.sv
module test_ptlb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic        wr_live = 1'b0;
    logic [7:0]  wr_tid = '0;
    logic        wr_ts = 1'b0;
    logic [3:0]  wr_size = '0;
    logic [21:0] wr_epn = '0;
    logic [21:0] wr_rpn = '0;
    logic [3:0]  wr_xrpn = '0;
    logic [3:0]  wr_uattr = '0;
    logic [4:0]  wr_stor = '0;
    logic [5:0]  wr_perm = '0;
    logic        inv_en = 1'b0;
    logic [5:0]  inv_idx = '0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_ea = '0;
    logic [7:0]  lk_tid = '0;
    logic        lk_ts = 1'b0;
    logic [1:0]  lk_acc = '0;
    logic        lk_super = 1'b0;
    logic        rs_valid, rs_hit, rs_multi, rs_fault;
    logic [5:0]  rs_idx;
    logic [35:0] rs_pa;
    logic [3:0]  rs_uattr;
    logic [4:0]  rs_stor;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ptlb_top i_ptlb_top (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected physical address from the page-size rule
    function automatic logic [35:0] exp_pa(input logic [3:0] x, input logic [31:0] rbase,
                                           input logic [31:0] ea, input int sz);
        logic [63:0] pg;
        logic [31:0] m;
        pg = 64'd1024 << (2 * sz);
        m  = 32'(pg - 1);
        return {x, (rbase & ~m) | (ea & m)};
    endfunction

    task automatic put(input int idx, input logic live, input logic [7:0] tid, input logic ts,
                       input logic [3:0] sz, input logic [31:0] ebase, input logic [31:0] rbase,
                       input logic [3:0] x, input logic [3:0] ua, input logic [4:0] st,
                       input logic [5:0] pm);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_live = live; wr_tid = tid; wr_ts = ts;
        wr_size = sz; wr_epn = ebase[31:10]; wr_rpn = rbase[31:10]; wr_xrpn = x;
        wr_uattr = ua; wr_stor = st; wr_perm = pm;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic kill(input int idx);
        @(negedge clk);
        inv_en = 1'b1; inv_idx = 6'(idx);
        @(negedge clk);
        inv_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] ea, input logic [7:0] tid, input logic ts,
                        input logic [1:0] acc, input logic sup);
        @(negedge clk);
        lk_req = 1'b1; lk_ea = ea; lk_tid = tid; lk_ts = ts; lk_acc = acc; lk_super = sup;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 valid low after reset", 64'(rs_valid), 64'd0);
        look(32'h1234_5678, 8'h00, 1'b0, 2'd0, 1'b0);
        check("R1 empty array misses", 64'(rs_hit), 64'd0);
        check("R2 valid one cycle after request", 64'(rs_valid), 64'd1);
        @(negedge clk);
        check("R2 valid drops without request", 64'(rs_valid), 64'd0);
    endtask

    task automatic t_basic;
        put(5, 1'b1, 8'h12, 1'b0, 4'd1, 32'h1234_5000, 32'h00AB_C000, 4'h3, 4'h9, 5'h15, 6'h3F);
        look(32'h1234_5ABC, 8'h12, 1'b0, 2'd0, 1'b1);
        check("R3 4K hit", 64'(rs_hit), 64'd1);
        check("R3 4K index", 64'(rs_idx), 64'd5);
        check("R5 4K address", 64'(rs_pa), 64'(exp_pa(4'h3, 32'h00AB_C000, 32'h1234_5ABC, 1)));
        check("R8 user attributes", 64'(rs_uattr), 64'h9);
        check("R8 storage attributes", 64'(rs_stor), 64'h15);
        check("R6 single hit no multi", 64'(rs_multi), 64'd0);
        look(32'h1234_5ABC, 8'h13, 1'b0, 2'd0, 1'b1);
        check("R3 ID mismatch misses", 64'(rs_hit), 64'd0);
        check("R8 miss zero address", 64'(rs_pa), 64'd0);
        look(32'h1234_5ABC, 8'h12, 1'b1, 2'd0, 1'b1);
        check("R3 space mismatch misses", 64'(rs_hit), 64'd0);
        look(32'h1234_6000, 8'h12, 1'b0, 2'd0, 1'b1);
        check("R3 next page misses", 64'(rs_hit), 64'd0);
    endtask

    task automatic t_sizes;
        put(10, 1'b1, 8'h21, 1'b1, 4'd9, 32'h9000_0000, 32'h7000_0000, 4'hA, 4'h1, 5'h02, 6'h3F);
        look(32'h9ABC_DEF0, 8'h21, 1'b1, 2'd0, 1'b0);
        check("R4 256M hit", 64'(rs_hit), 64'd1);
        check("R5 256M address", 64'(rs_pa), 64'(exp_pa(4'hA, 32'h7000_0000, 32'h9ABC_DEF0, 9)));
        look(32'hA000_0000, 8'h21, 1'b1, 2'd0, 1'b0);
        check("R4 256M outside misses", 64'(rs_hit), 64'd0);
        put(12, 1'b1, 8'h33, 1'b0, 4'd6, 32'h6000_0000, 32'h0100_0000, 4'h0, 4'h0, 5'h00, 6'h3F);
        look(32'h6000_0010, 8'h33, 1'b0, 2'd0, 1'b0);
        check("R4 unsupported code never matches", 64'(rs_hit), 64'd0);
        put(12, 1'b1, 8'h33, 1'b0, 4'd7, 32'h6000_0000, 32'h0100_0000, 4'h0, 4'h0, 5'h00, 6'h3F);
        look(32'h60FF_1234, 8'h33, 1'b0, 2'd0, 1'b0);
        check("R4 16M hit", 64'(rs_hit), 64'd1);
        check("R5 16M address", 64'(rs_pa), 64'(exp_pa(4'h0, 32'h0100_0000, 32'h60FF_1234, 7)));
    endtask

    task automatic t_multi;
        put(20, 1'b1, 8'h40, 1'b0, 4'd5, 32'h4000_0000, 32'h0AB0_0000, 4'h1, 4'h2, 5'h01, 6'h3F);
        put(3,  1'b1, 8'h40, 1'b0, 4'd0, 32'h4000_0400, 32'h0000_0800, 4'h2, 4'h4, 5'h08, 6'h3F);
        look(32'h4000_0523, 8'h40, 1'b0, 2'd0, 1'b0);
        check("R6 lowest index wins", 64'(rs_idx), 64'd3);
        check("R6 multi flag", 64'(rs_multi), 64'd1);
        check("R5 1K address", 64'(rs_pa), 64'(exp_pa(4'h2, 32'h0000_0800, 32'h4000_0523, 0)));
        check("R8 attributes of winner", 64'(rs_stor), 64'h08);
        look(32'h4008_1234, 8'h40, 1'b0, 2'd0, 1'b0);
        check("R6 large page only", 64'(rs_idx), 64'd20);
        check("R6 no multi", 64'(rs_multi), 64'd0);
        check("R5 1M address", 64'(rs_pa), 64'(exp_pa(4'h1, 32'h0AB0_0000, 32'h4008_1234, 5)));
    endtask

    task automatic t_perm;
        // user exec, user read, supervisor write granted
        put(40, 1'b1, 8'h55, 1'b0, 4'd2, 32'h0002_0000, 32'h0030_0000, 4'h0, 4'h0, 5'h00, 6'b101010);
        look(32'h0002_0100, 8'h55, 1'b0, 2'd0, 1'b0); check("R7 user read ok",     64'(rs_fault), 64'd0);
        look(32'h0002_0100, 8'h55, 1'b0, 2'd1, 1'b0); check("R7 user write fault", 64'(rs_fault), 64'd1);
        look(32'h0002_0100, 8'h55, 1'b0, 2'd2, 1'b0); check("R7 user exec ok",     64'(rs_fault), 64'd0);
        look(32'h0002_0100, 8'h55, 1'b0, 2'd0, 1'b1); check("R7 super read fault", 64'(rs_fault), 64'd1);
        look(32'h0002_0100, 8'h55, 1'b0, 2'd1, 1'b1); check("R7 super write ok",   64'(rs_fault), 64'd0);
        look(32'h0002_0100, 8'h55, 1'b0, 2'd2, 1'b1); check("R7 super exec fault", 64'(rs_fault), 64'd1);
        look(32'h0002_0100, 8'h55, 1'b0, 2'd3, 1'b0); check("R7 code 3 as read",   64'(rs_fault), 64'd0);
        look(32'h0003_0100, 8'h55, 1'b0, 2'd1, 1'b0); check("R7 miss never faults", 64'(rs_fault), 64'd0);
    endtask

    task automatic t_update;
        kill(5);
        look(32'h1234_5ABC, 8'h12, 1'b0, 2'd0, 1'b1);
        check("R9 invalidated entry misses", 64'(rs_hit), 64'd0);
        // write and invalidate the same index together
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'd31; wr_live = 1'b1; wr_tid = 8'h66; wr_ts = 1'b0;
        wr_size = 4'd1; wr_epn = 22'(32'h5000_0000 >> 10); wr_rpn = '0; wr_xrpn = '0;
        wr_perm = 6'h3F; inv_en = 1'b1; inv_idx = 6'd31;
        @(negedge clk);
        wr_en = 1'b0; inv_en = 1'b0;
        look(32'h5000_0010, 8'h66, 1'b0, 2'd0, 1'b0);
        check("R9 invalidate wins collision", 64'(rs_hit), 64'd0);
        // write and lookup in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'd30; wr_live = 1'b1; wr_tid = 8'h77; wr_ts = 1'b0;
        wr_size = 4'd1; wr_epn = 22'(32'h7700_0000 >> 10); wr_rpn = 22'(32'h0012_3000 >> 10);
        wr_xrpn = 4'h5; wr_perm = 6'h3F;
        lk_req = 1'b1; lk_ea = 32'h7700_0444; lk_tid = 8'h77; lk_ts = 1'b0; lk_acc = 2'd0;
        @(negedge clk);
        wr_en = 1'b0; lk_req = 1'b0;
        check("R10 same-cycle lookup sees old", 64'(rs_hit), 64'd0);
        look(32'h7700_0444, 8'h77, 1'b0, 2'd0, 1'b0);
        check("R10 next-cycle lookup sees new", 64'(rs_hit), 64'd1);
        check("R10 new entry address", 64'(rs_pa), 64'(exp_pa(4'h5, 32'h0012_3000, 32'h7700_0444, 1)));
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_sizes();
        t_multi();
        t_perm();
        t_update();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule